// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Qualifier

This block takes the raw address-match hits of a set of hardware breakpoint and watchpoint slots and decides which of them may actually raise a debug event. Address comparison happens upstream. Each slot's 64-bit control word carries packed fields that restrict a match in three ways: by security state, by exception level, and optionally by a link to a context-aware breakpoint whose value register must equal the current context ID. A global enable and a "debug exceptions permitted" input gate every slot.

Each slot drives a combinational qualified hit. A registered event output, one cycle later, reports whether any slot qualified and the index of the lowest-numbered one. Breakpoints occupy indices 0 to NUM_BP-1 and watchpoints follow them. The slot counts, the number of context-aware breakpoints and the register widths are parameters. The defaults are 6 breakpoints (the top 2 context-aware) and 4 watchpoints.

Control-word fields used (bit positions): enable [0], privilege select [2:1], high-level enable [13], security select [15:14], link target [19:16], link flag [20], breakpoint type [23:20].

Top module: `dbg_hit_qualifier`

## Requirements
- R1: A slot qualifies only when its raw hit input is 1 and its control bit 0 (enable) is 1.
- R2: Security select (control bits 15:14) value 0 allows either state. Values 1 and 3 allow only non-secure (`secure`=0). Value 2 allows only secure (`secure`=1).
- R3: At an effective level of 2 or 3 a slot needs control bit 13 set. At level 1 it needs control bit 1 set. At level 0 it needs control bit 2 set.
- R4: For watchpoints, `unpriv_acc`=1 makes the effective level 0 regardless of `cur_el`. Breakpoints always use `cur_el`.
- R5: When control bit 20 (link flag) is 1, a slot qualifies only if the breakpoint named by control bits 19:16 passes the link-target check.
- R6: A link target index below NUM_BP-NUM_CTX or above NUM_BP-1 always fails the link-target check.
- R7: A link target passes only if its control bit 0 is 1, its bits 23:20 equal 3, `cur_el` is 0 or 1, and `ctx_id` equals bits 31:0 of its value register. This holds whether or not the target has a raw hit.
- R8: No slot qualifies unless both `dbg_global_en` and `dbg_permit` are 1.
- R9: `evt_valid` equals the OR of all qualified hits of the previous clock cycle.
- R10: `evt_slot` gives the lowest index among the previous cycle's qualified hits. Breakpoint i has index i and watchpoint j has index NUM_BP+j. It is 0 when `evt_valid` is 0.
- R11: While `rst_n` is 0, `evt_valid` and `evt_slot` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bp_raw_hit | input | NUM_BP | Raw address hit per breakpoint |
| bp_ctrl | input | NUM_BP*CTRL_W | Breakpoint control words, slot i at bits i*CTRL_W upward |
| bp_value | input | NUM_BP*VAL_W | Breakpoint value words, slot i at bits i*VAL_W upward |
| wp_raw_hit | input | NUM_WP | Raw address hit per watchpoint |
| wp_ctrl | input | NUM_WP*CTRL_W | Watchpoint control words |
| cur_el | input | 2 | Current exception level 0..3 |
| secure | input | 1 | 1 = secure state |
| unpriv_acc | input | 1 | Current data access is an unprivileged-form access |
| dbg_global_en | input | 1 | Global breakpoint/watchpoint enable |
| dbg_permit | input | 1 | Debug exceptions currently permitted |
| ctx_id | input | 32 | Current context ID |
| bp_qual | output | NUM_BP | Qualified hit per breakpoint |
| wp_qual | output | NUM_WP | Qualified hit per watchpoint |
| evt_valid | output | 1 | Registered: some slot qualified last cycle |
| evt_slot | output | IDX_W | Registered: lowest qualifying slot index |

## Verification
The hardest case to reach is a linked slot whose target passes every link-target condition except one: out-of-range index, wrong type, a disabled target, a level above 1, or a context ID that misses by some bits. It is hard because the target's own control word also shapes its own qualification. The stimulus sweeps every link index 0..15 against every type code, target enable, context match and level, with all raw hits set. Linking slots and targets are then judged together in the same vector.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;

   localparam int unsigned LBN_SPAN = 16;
   localparam int unsigned CTX_W    = 32;
   localparam logic [3:0]  CTX_MATCH_TYPE = 4'd3;

   typedef enum logic [1:0] {
      SEC_EITHER  = 2'd0,
      SEC_NS_LO   = 2'd1,
      SEC_ONLY_S  = 2'd2,
      SEC_NS_HI   = 2'd3
   } sec_sel_e;

   typedef struct packed {
      logic [3:0] btype;
      logic       linked;
      logic [3:0] lbn;
      logic [1:0] ssc;
      logic       hmc;
      logic [1:0] pac;
      logic       en;
   } slot_fld_t;

   function automatic slot_fld_t decode_ctrl(input logic [23:13] hi,
                                             input logic [2:0]   lo);
      slot_fld_t f;
      f.en     = lo[0];
      f.pac    = lo[2:1];
      f.hmc    = hi[13];
      f.ssc    = hi[15:14];
      f.lbn    = hi[19:16];
      f.linked = hi[20];
      f.btype  = hi[23:20];
      return f;
   endfunction

endpackage

// File: rtl/dbgq_link_eval.sv
module dbgq_link_eval
   import dbgq_pkg::*;
#(
   parameter int NUM_BP  = 6,
   parameter int NUM_CTX = 2
) (
   input  slot_fld_t [NUM_BP-1:0]             bp_fld,
   input  logic      [NUM_BP-1:0][CTX_W-1:0]  bp_ctx_val,
   input  logic      [1:0]                    cur_el,
   input  logic      [CTX_W-1:0]              ctx_id,
   output logic      [LBN_SPAN-1:0]           link_ok
);

   localparam int CTX_LO = NUM_BP - NUM_CTX;

   logic low_level;
   assign low_level = (cur_el <= 2'd1);

   // fold inputs that only context-aware slots consume
   logic unused_fold;
   assign unused_fold = ^{bp_fld, bp_ctx_val};

   for (genvar i = 0; i < LBN_SPAN; i++) begin : g_tgt
      if (i >= CTX_LO && i < NUM_BP) begin : g_ctx
         assign link_ok[i] = bp_fld[i].en
                           && (bp_fld[i].btype == CTX_MATCH_TYPE)
                           && low_level
                           && (ctx_id == bp_ctx_val[i]);
      end else begin : g_none
         assign link_ok[i] = 1'b0;
      end
   end

endmodule

// File: rtl/dbgq_slot_filter.sv
module dbgq_slot_filter
   import dbgq_pkg::*;
#(
   parameter bit IS_WP   = 1'b0,
   parameter int NUM_BP  = 6,
   parameter int NUM_CTX = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                raw_hit,
   input  slot_fld_t           fld,
   input  logic [1:0]          cur_el,
   input  logic                secure,
   input  logic                unpriv,
   input  logic                gate,
   input  logic [LBN_SPAN-1:0] link_ok,
   output logic                qual
);

   localparam logic WP_BIT = IS_WP;

   logic [1:0] eff_el;
   logic       sec_ok;
   logic       lvl_ok;
   logic       lnk_ok;

   assign eff_el = (WP_BIT && unpriv) ? 2'd0 : cur_el;

   always_comb begin
      unique case (sec_sel_e'(fld.ssc))
         SEC_EITHER: sec_ok = 1'b1;
         SEC_ONLY_S: sec_ok = secure;
         default:    sec_ok = !secure;
      endcase
   end

   always_comb begin
      unique case (eff_el)
         2'd3, 2'd2: lvl_ok = fld.hmc;
         2'd1:       lvl_ok = fld.pac[0];
         default:    lvl_ok = fld.pac[1];
      endcase
   end

   assign lnk_ok = !fld.linked || link_ok[fld.lbn];

   assign qual = gate && raw_hit && fld.en && sec_ok && lvl_ok && lnk_ok;

   // R1
   raw_and_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qual |-> (raw_hit && fld.en));

   // R2
   secure_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && fld.ssc == 2'd2) |-> secure);

   // R3
   high_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && cur_el >= 2'd2 && !(WP_BIT && unpriv)) |-> fld.hmc);

   // R4
   unpriv_as_el0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && WP_BIT && unpriv) |-> fld.pac[1]);

   // R6
   link_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && fld.linked) |->
         (int'(fld.lbn) >= NUM_BP - NUM_CTX && int'(fld.lbn) < NUM_BP));

   // R7
   link_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && fld.linked) |-> (cur_el <= 2'd1));

endmodule

// File: rtl/dbgq_event_reg.sv
module dbgq_event_reg #(
   parameter int SLOTS = 10,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] hits,
   output logic             evt_valid,
   output logic [IDX_W-1:0] evt_slot
);

   localparam logic [SLOTS-1:0] ONE = {{(SLOTS-1){1'b0}}, 1'b1};

   logic [IDX_W-1:0] nxt_idx;
   logic             any_hit;

   always_comb begin
      nxt_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (hits[i]) nxt_idx = IDX_W'(i);
      end
   end

   assign any_hit = |hits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_valid <= 1'b0;
         evt_slot  <= '0;
      end else begin
         evt_valid <= any_hit;
         evt_slot  <= nxt_idx;
      end
   end

   // R9
   evt_follows_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (evt_valid == ($past(hits) != '0)));

   // R10
   evt_slot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> ((($past(hits) >> evt_slot) & ONE) != '0));

   // R10
   evt_slot_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (($past(hits) & ((ONE << evt_slot) - ONE)) == '0));

   // R10
   evt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |-> (evt_slot == '0));

endmodule

// File: rtl/dbg_hit_qualifier.sv
module dbg_hit_qualifier
   import dbgq_pkg::*;
#(
   parameter int NUM_BP  = 6,
   parameter int NUM_CTX = 2,
   parameter int NUM_WP  = 4,
   parameter int CTRL_W  = 64,
   parameter int VAL_W   = 64,
   localparam int SLOTS  = NUM_BP + NUM_WP,
   localparam int IDX_W  = $clog2(SLOTS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_BP-1:0]        bp_raw_hit,
   input  logic [NUM_BP*CTRL_W-1:0] bp_ctrl,
   input  logic [NUM_BP*VAL_W-1:0]  bp_value,
   input  logic [NUM_WP-1:0]        wp_raw_hit,
   input  logic [NUM_WP*CTRL_W-1:0] wp_ctrl,
   input  logic [1:0]               cur_el,
   input  logic                     secure,
   input  logic                     unpriv_acc,
   input  logic                     dbg_global_en,
   input  logic                     dbg_permit,
   input  logic [31:0]              ctx_id,
   output logic [NUM_BP-1:0]        bp_qual,
   output logic [NUM_WP-1:0]        wp_qual,
   output logic                     evt_valid,
   output logic [IDX_W-1:0]         evt_slot
);

   if (NUM_BP < 1 || NUM_BP > LBN_SPAN || NUM_CTX < 0 || NUM_CTX > NUM_BP
       || NUM_WP < 1 || CTRL_W <= 24 || VAL_W <= CTX_W) begin : g_bad_cfg
      $error("dbg_hit_qualifier: unsupported parameter combination");
   end

   slot_fld_t [NUM_BP-1:0]            bp_fld;
   logic      [NUM_BP-1:0][CTX_W-1:0] bp_ctx_val;
   logic      [LBN_SPAN-1:0]          link_ok;
   logic      [NUM_BP-1:0]            unused_bp;
   logic      [NUM_WP-1:0]            unused_wp;
   logic                              gate;

   assign gate = dbg_global_en && dbg_permit;

   for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
      logic [CTRL_W-1:0] c;
      assign c             = bp_ctrl[i*CTRL_W +: CTRL_W];
      assign bp_fld[i]     = decode_ctrl(c[23:13], c[2:0]);
      assign bp_ctx_val[i] = bp_value[i*VAL_W +: CTX_W];
      assign unused_bp[i]  = ^{c[CTRL_W-1:24], c[12:3],
                               bp_value[i*VAL_W+CTX_W +: VAL_W-CTX_W]};

      dbgq_slot_filter #(.IS_WP(1'b0), .NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_flt (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_hit (bp_raw_hit[i]),
         .fld     (bp_fld[i]),
         .cur_el  (cur_el),
         .secure  (secure),
         .unpriv  (unpriv_acc),
         .gate    (gate),
         .link_ok (link_ok),
         .qual    (bp_qual[i])
      );
   end

   for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
      logic [CTRL_W-1:0] c;
      slot_fld_t         fld;
      assign c            = wp_ctrl[j*CTRL_W +: CTRL_W];
      assign fld          = decode_ctrl(c[23:13], c[2:0]);
      assign unused_wp[j] = ^{c[CTRL_W-1:24], c[12:3], fld.btype};

      dbgq_slot_filter #(.IS_WP(1'b1), .NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_flt (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_hit (wp_raw_hit[j]),
         .fld     (fld),
         .cur_el  (cur_el),
         .secure  (secure),
         .unpriv  (unpriv_acc),
         .gate    (gate),
         .link_ok (link_ok),
         .qual    (wp_qual[j])
      );
   end

   dbgq_link_eval #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_link (
      .bp_fld     (bp_fld),
      .bp_ctx_val (bp_ctx_val),
      .cur_el     (cur_el),
      .ctx_id     (ctx_id),
      .link_ok    (link_ok)
   );

   dbgq_event_reg #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .hits      ({wp_qual, bp_qual}),
      .evt_valid (evt_valid),
      .evt_slot  (evt_slot)
   );

   // R8
   gate_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dbg_global_en && dbg_permit) |-> (bp_qual == '0 && wp_qual == '0));

   // R11
   always_ff @(posedge clk) begin
      reset_clear_chk: assert (rst_n || (!evt_valid && evt_slot == '0));
   end

endmodule

// File: tb/sim_dbg_hit_qualifier.sv
`timescale 1ns/1ps
module sim_dbg_hit_qualifier;

   localparam int NB = 6;
   localparam int NC = 2;
   localparam int NW = 4;
   localparam int NS = NB + NW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [63:0] bctl [NB];
   logic [63:0] bval [NB];
   logic [63:0] wctl [NW];
   logic [NB-1:0] braw;
   logic [NW-1:0] wraw;
   logic [1:0]  el;
   logic        sec, unp, gen, perm;
   logic [31:0] ctx;

   logic [NB*64-1:0] bctl_f, bval_f;
   logic [NW*64-1:0] wctl_f;
   logic [NB-1:0] bp_qual;
   logic [NW-1:0] wp_qual;
   logic          evt_valid;
   logic [3:0]    evt_slot;

   always_comb begin
      for (int i = 0; i < NB; i++) begin
         bctl_f[i*64 +: 64] = bctl[i];
         bval_f[i*64 +: 64] = bval[i];
      end
      for (int j = 0; j < NW; j++) wctl_f[j*64 +: 64] = wctl[j];
   end

   dbg_hit_qualifier u0 (
      .clk(clk), .rst_n(rst_n),
      .bp_raw_hit(braw), .bp_ctrl(bctl_f), .bp_value(bval_f),
      .wp_raw_hit(wraw), .wp_ctrl(wctl_f),
      .cur_el(el), .secure(sec), .unpriv_acc(unp),
      .dbg_global_en(gen), .dbg_permit(perm), .ctx_id(ctx),
      .bp_qual(bp_qual), .wp_qual(wp_qual),
      .evt_valid(evt_valid), .evt_slot(evt_slot)
   );

   int checks = 0;
   int fails  = 0;
   logic [31:0] rs = 32'h1234_5679;

   function automatic logic [31:0] rnd(inout logic [31:0] s);
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      return s;
   endfunction

   function automatic logic [63:0] mk(input logic en, input logic [1:0] pac,
                                      input logic hmc, input logic [1:0] ssc,
                                      input logic [3:0] lbn, input logic [3:0] typ);
      logic [63:0] c = '0;
      c[0] = en; c[2:1] = pac; c[13] = hmc; c[15:14] = ssc;
      c[19:16] = lbn; c[23:20] = typ;
      return c;
   endfunction

   // expected qualification computed from the requirement text
   function automatic logic [NS-1:0] model();
      logic [NS-1:0] e = '0;
      for (int s = 0; s < NS; s++) begin
         logic [63:0] c;
         logic r, ok, need;
         int lv, t;
         c  = (s < NB) ? bctl[s] : wctl[s-NB];
         r  = (s < NB) ? braw[s] : wraw[s-NB];
         ok = gen && perm && r && c[0];                        // R8 R1
         if (c[15:14] == 2'd2 && !sec) ok = 0;                 // R2
         if ((c[15:14] == 2'd1 || c[15:14] == 2'd3) && sec) ok = 0;
         lv = (s >= NB && unp) ? 0 : int'(el);                 // R4
         need = (lv >= 2) ? c[13] : (lv == 1) ? c[1] : c[2];   // R3
         if (!need) ok = 0;
         if (c[20]) begin                                      // R5
            t = int'(c[19:16]);
            if (t < NB - NC || t > NB - 1) ok = 0;             // R6
            else if (!bctl[t][0] || bctl[t][23:20] != 4'd3 ||
                     el > 2'd1 || ctx != bval[t][31:0]) ok = 0; // R7
         end
         e[s] = ok;
      end
      return e;
   endfunction

   task automatic step(input string tag);
      logic [NS-1:0] e;
      int lo;
      #1;
      e = model();
      checks++;
      if ({wp_qual, bp_qual} !== e) begin
         fails++;
         $display("FAIL %s qualified hits actual %b expected %b", tag, {wp_qual, bp_qual}, e);
      end
      lo = 0;
      for (int k = NS - 1; k >= 0; k--) if (e[k]) lo = k;
      @(negedge clk);
      checks++;
      if (evt_valid !== (|e) || evt_slot !== 4'(lo)) begin
         fails++;
         $display("FAIL R9 R10 (%s) event actual %b/%0d expected %b/%0d",
                  tag, evt_valid, evt_slot, |e, lo);
      end
   endtask

   task automatic fill_all(input logic [63:0] c);
      for (int i = 0; i < NB; i++) bctl[i] = c;
      for (int j = 0; j < NW; j++) wctl[j] = c;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      fill_all(mk(1, 2'd3, 1, 2'd0, 4'd0, 4'd0));
      for (int i = 0; i < NB; i++) bval[i] = '0;
      braw = '1; wraw = '1; el = 0; sec = 0; unp = 0; gen = 1; perm = 1; ctx = 0;
      repeat (3) @(negedge clk);
      // R11: reset holds event outputs at zero despite live hits
      checks++;
      if (evt_valid !== 1'b0 || evt_slot !== 4'd0) begin
         fails++;
         $display("FAIL R11 reset actual %b/%0d expected 0/0", evt_valid, evt_slot);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4: security, level and unprivileged sweep
      for (int l = 0; l < 4; l++)
         for (int s = 0; s < 2; s++)
            for (int u = 0; u < 2; u++)
               for (int ss = 0; ss < 4; ss++)
                  for (int p = 0; p < 4; p++)
                     for (int h = 0; h < 2; h++) begin
                        el = 2'(l); sec = s[0]; unp = u[0];
                        fill_all(mk(1, 2'(p), h[0], 2'(ss), 4'd0, 4'd0));
                        step("R2 R3 R4");
                     end

      // R1 R10: every raw-hit pattern with scattered enables
      el = 1; sec = 0; unp = 0;
      for (int pat = 0; pat < 1024; pat++) begin
         logic [31:0] r;
         r = rnd(rs);
         {wraw, braw} = 10'(pat);
         for (int i = 0; i < NB; i++) bctl[i] = mk(r[i] | r[20], 2'd3, 1, 2'd0, 4'd0, 4'd0);
         for (int j = 0; j < NW; j++) wctl[j] = mk(r[NB+j] | r[21], 2'd3, 1, 2'd0, 4'd0, 4'd0);
         step("R1");
      end

      // R5 R6 R7: link index x target type x enable x context x level
      braw = '1; wraw = '1; sec = 0;
      for (int lb = 0; lb < 16; lb++)
         for (int ty = 0; ty < 16; ty++)
            for (int te = 0; te < 2; te++)
               for (int cm = 0; cm < 2; cm++)
                  for (int l = 0; l < 4; l++) begin
                     logic [31:0] r;
                     r = rnd(rs);
                     el = 2'(l); unp = r[0];
                     fill_all(mk(1, 2'd3, 1, 2'd0, 4'(lb), 4'd1));
                     for (int i = 0; i < NB; i++) bval[i] = {rnd(rs), rnd(rs)};
                     if (lb < NB) bctl[lb] = mk(te[0], 2'd3, 1, 2'd0, 4'(lb), 4'(ty));
                     ctx = (lb < NB) ? bval[lb][31:0] : r;
                     if (!cm[0]) ctx = ctx ^ (32'h1 << r[8:4]);
                     step("R5 R6 R7");
                  end

      // R8: global gate combinations with random control words
      for (int g = 0; g < 4; g++)
         for (int n = 0; n < 64; n++) begin
            logic [31:0] r;
            r = rnd(rs);
            gen = g[0]; perm = g[1];
            el = r[1:0]; sec = r[2]; unp = r[3];
            {wraw, braw} = r[13:4];
            fill_all(mk(1, r[15:14], r[16], r[18:17] & {r[19], 1'b1}, 4'd0, 4'd0));
            step("R8");
         end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule